// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the clock waveform that an I2C master places on SCL. Two programmable counts set how long the line is held low and how long it is left high. Both counts are in prescaled ticks, and a separate input sets how many system clocks make up one tick. Each count is an 8-bit base value plus one extension bit. When the extension option is built in, the extension bit raises the count to 9 bits.

The low phase starts at the same moment the block begins pulling SCL low. The fall time of the line is therefore inside the low count. After the low phase the block releases the line and watches the real SCL level through a two-flop synchronizer. The high count starts only once the line is seen high. A slow rise time or a slave holding SCL low therefore stretches the period, and the high phase is never shortened.

A byte engine beside this block uses two single-cycle strobes. One marks the middle of each low phase, where SDA may change. The other marks the first cycle of each high phase, where SDA is sampled. Clearing the enable releases the line at once and returns every counter to zero.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is active or `enable` is low, `sclDriveLow`, `sampleStrobe` and `changeStrobe` are all 0.
- R2: In the cycle after `enable` is first seen high, `sclDriveLow` is 1. It then stays 1 for exactly L*N system clocks, where L is the effective low count and N is the effective clocks per tick.
- R3: The effective count is 9 bits wide. The extension bit is bit 8 and the 8-bit count is bits 7..0, so the largest count, 0x1FF, gives 511 ticks.
- R4: A count whose 9-bit value is zero acts as a count of one tick.
- R5: One tick lasts `clksPerCount` system clocks. A value of zero acts as one clock.
- R6: After the line is released, `sampleStrobe` pulses for one cycle exactly 3 system clocks after the first cycle in which `sclIn` is high. That pulse is the first cycle of the high phase.
- R7: While `sclIn` stays low after release (a stretching slave), no high phase begins, `sampleStrobe` stays 0 and `sclDriveLow` stays 0.
- R8: The high phase lasts exactly H*N system clocks, counted from the `sampleStrobe` cycle. `sclDriveLow` returns to 1 in the cycle after the high phase ends.
- R9: `changeStrobe` pulses exactly once per low phase. It falls on low-phase cycle floor(L/2)*N, counting the first low cycle as cycle 0.
- R10: When `enable` goes low, `sclDriveLow` is 0 from the next cycle onward and no strobe occurs. When `enable` is raised again, a complete low phase of L*N clocks begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator while high |
| lowCount | input | 8 | Low-phase count, bits 7..0 |
| lowExt | input | 1 | Low-phase count bit 8 |
| highCount | input | 8 | High-phase count, bits 7..0 |
| highExt | input | 1 | High-phase count bit 8 |
| clksPerCount | input | 4 | System clocks per tick (0 acts as 1) |
| sclIn | input | 1 | Raw sensed SCL line level |
| sclDriveLow | output | 1 | 1 = pull SCL low, 0 = release it |
| sampleStrobe | output | 1 | One-cycle pulse at the start of each high phase |
| changeStrobe | output | 1 | One-cycle pulse at the middle of each low phase |

## Verification
The bench samples every output on the falling clock edge and measures each phase as a count of cycles. Enable shows up on `sclDriveLow` one cycle after it is sampled. The low phase then takes L*N cycles. `changeStrobe` falls floor(L/2)*N cycles into that phase. `sampleStrobe` comes exactly three cycles after the released line is high, and the drive returns H*N cycles after that. The bench drives `sclIn` as an open-drain loopback of `sclDriveLow` combined with an optional stretch. Each measured count is compared against the value computed from these formulas, and stimulus changes only on the falling edge so that the counts start from a known cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOW     = 2'd1,
    ST_RELEASE = 2'd2,
    ST_HIGH    = 2'd3
  } sclState_t;

  // control -> datapath
  typedef struct packed {
    logic clear;     // zero prescaler and phase counter
    logic count;     // advance prescaler / phase counter
    logic useHigh;   // compare against high count instead of low
    logic waitLine;  // release phase: run sync guard
  } dpCmd_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone; // last clock of the current counted phase
    logic atMid;     // first clock of the low-phase midpoint tick
    logic atStart;   // first clock of a counted phase
    logic lineReady; // synchronized line high after guard window
  } dpStat_t;

endpackage

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int BASE_W      = 8,
  parameter int HAS_EXT     = 1,
  parameter int PRESC_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [BASE_W-1:0]  lowCount,
  input  logic               lowExt,
  input  logic [BASE_W-1:0]  highCount,
  input  logic               highExt,
  input  logic [PRESC_W-1:0] clksPerCount,
  input  logic               sclIn,
  output dpStat_t            stat
);

  localparam int CNT_W   = BASE_W + 1;
  localparam int GUARD_W = $clog2(SYNC_STAGES + 1);
  localparam logic [GUARD_W-1:0] GUARD_MAX = GUARD_W'(SYNC_STAGES);

  logic [CNT_W-1:0]       lowRaw, highRaw, lowEff, highEff, limit, midPoint;
  logic [CNT_W-1:0]       phaseCnt;
  logic [PRESC_W-1:0]     tickCnt, divEff;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [GUARD_W-1:0]     guardCnt;
  logic                   lastClk;

  // Extension bit is a build option
  generate
    if (HAS_EXT != 0) begin : g_ext
      assign lowRaw  = {lowExt, lowCount};
      assign highRaw = {highExt, highCount};
    end else begin : g_noExt
      logic unusedExt;
      assign unusedExt = lowExt ^ highExt;
      assign lowRaw    = {1'b0, lowCount};
      assign highRaw   = {1'b0, highCount};
    end
  endgenerate

  assign lowEff   = (lowRaw == '0) ? CNT_W'(1) : lowRaw;
  assign highEff  = (highRaw == '0) ? CNT_W'(1) : highRaw;
  assign divEff   = (clksPerCount == '0) ? PRESC_W'(1) : clksPerCount;
  assign limit    = cmd.useHigh ? highEff : lowEff;
  assign midPoint = lowEff >> 1;

  // Line synchronizer (idle bus level is high)
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
  end

  // Guard window covering synchronizer latency after release
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.waitLine)  guardCnt <= '0;
    else if (guardCnt != GUARD_MAX) guardCnt <= guardCnt + 1'b1;
  end

  assign lastClk = (tickCnt == divEff - 1'b1);

  // Prescaler and phase counter
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      tickCnt  <= '0;
      phaseCnt <= '0;
    end else if (cmd.count) begin
      if (lastClk) begin
        tickCnt  <= '0;
        phaseCnt <= stat.phaseDone ? '0 : phaseCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign stat.phaseDone = lastClk && (phaseCnt == limit - 1'b1);
  assign stat.atStart   = (tickCnt == '0) && (phaseCnt == '0);
  assign stat.atMid     = (tickCnt == '0) && (phaseCnt == midPoint);
  assign stat.lineReady = syncQ[SYNC_STAGES-1] && (guardCnt == GUARD_MAX);

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    sclDriveLow,
  output logic    sampleStrobe,
  output logic    changeStrobe
);

  sclState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    stateNext = ST_LOW;
      ST_LOW:     if (stat.phaseDone) stateNext = ST_RELEASE;
      ST_RELEASE: if (stat.lineReady) stateNext = ST_HIGH;
      ST_HIGH:    if (stat.phaseDone) stateNext = ST_LOW;
      default:    stateNext = ST_IDLE;
    endcase
    if (!enable) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmd.clear    = (state == ST_IDLE) || (state == ST_RELEASE);
  assign cmd.count    = (state == ST_LOW) || (state == ST_HIGH);
  assign cmd.useHigh  = (state == ST_HIGH);
  assign cmd.waitLine = (state == ST_RELEASE);

  assign sclDriveLow  = (state == ST_LOW);
  assign changeStrobe = (state == ST_LOW) && stat.atMid;
  assign sampleStrobe = (state == ST_HIGH) && stat.atStart;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int BASE_W      = 8,
  parameter int HAS_EXT     = 1,
  parameter int PRESC_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [BASE_W-1:0]  lowCount,
  input  logic               lowExt,
  input  logic [BASE_W-1:0]  highCount,
  input  logic               highExt,
  input  logic [PRESC_W-1:0] clksPerCount,
  input  logic               sclIn,
  output logic               sclDriveLow,
  output logic               sampleStrobe,
  output logic               changeStrobe
);

  dpCmd_t  cmd;
  dpStat_t stat;

  scl_gen_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .stat         (stat),
    .cmd          (cmd),
    .sclDriveLow  (sclDriveLow),
    .sampleStrobe (sampleStrobe),
    .changeStrobe (changeStrobe)
  );

  scl_gen_dp #(
    .BASE_W      (BASE_W),
    .HAS_EXT     (HAS_EXT),
    .PRESC_W     (PRESC_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .lowCount     (lowCount),
    .lowExt       (lowExt),
    .highCount    (highCount),
    .highExt      (highExt),
    .clksPerCount (clksPerCount),
    .sclIn        (sclIn),
    .stat         (stat)
  );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclIn,
  input logic sclDriveLow,
  input logic sampleStrobe,
  input logic changeStrobe
);

  // R10
  drive_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  // R2
  drive_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> $past(enable));

  // R6
  sample_while_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> !sclDriveLow);

  // R6
  sample_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R7
  sample_after_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(sclIn, 3));

  // R9
  change_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    changeStrobe |-> sclDriveLow);

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(changeStrobe && sampleStrobe));

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .sclIn        (sclIn),
  .sclDriveLow  (sclDriveLow),
  .sampleStrobe (sampleStrobe),
  .changeStrobe (changeStrobe)
);

// File: tb/tb_scl_clock_gen.sv
`timescale 1ns/1ps
module tb_scl_clock_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] lowCount = 8'd0, highCount = 8'd0;
  logic       lowExt = 1'b0, highExt = 1'b0;
  logic [3:0] clksPerCount = 4'd1;
  logic       stretch = 1'b0;
  logic       sclIn, sclDriveLow, sampleStrobe, changeStrobe;

  int checks = 0, fails = 0;
  int lowLen, midIdx, midCnt, relLen, highLen;

  always #2 clk = ~clk;  // 250 MHz

  assign sclIn = !sclDriveLow && !stretch;  // open-drain loopback

  scl_clock_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lowCount(lowCount), .lowExt(lowExt),
    .highCount(highCount), .highExt(highExt),
    .clksPerCount(clksPerCount), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .sampleStrobe(sampleStrobe),
    .changeStrobe(changeStrobe)
  );

  task automatic check(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic configure(int l, int h, int n);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    lowCount = l[7:0]; lowExt = l[8];
    highCount = h[7:0]; highExt = h[8];
    clksPerCount = n[3:0];
  endtask

  // Measure one full period starting at a low phase boundary
  task automatic measure();
    do @(negedge clk); while (sclDriveLow);
    do @(negedge clk); while (!sclDriveLow);
    lowLen = 0; midIdx = -1; midCnt = 0;
    while (sclDriveLow) begin
      if (changeStrobe) begin
        midCnt++;
        if (midIdx < 0) midIdx = lowLen;
      end
      lowLen++;
      @(negedge clk);
    end
    relLen = 0;
    while (!sampleStrobe) begin relLen++; @(negedge clk); end
    highLen = 0;
    while (!sclDriveLow) begin highLen++; @(negedge clk); end
  endtask

  task automatic runPeriod(string tag, int l, int h, int n, int el, int eh, int en);
    configure(l, h, n);
    enable = 1'b1;
    @(negedge clk);
    check({tag, " R2 drive one cycle after enable"}, sclDriveLow, 1);
    measure();
    check({tag, " R2 low length"}, lowLen, el * en);
    check({tag, " R9 change strobe index"}, midIdx, (el / 2) * en);
    check({tag, " R9 change strobe count"}, midCnt, 1);
    check({tag, " R6 release to sample"}, relLen, 3);
    check({tag, " R8 high length"}, highLen, eh * en);
  endtask

  task automatic testReset();
    int bad = 0;
    repeat (3) begin
      @(negedge clk);
      if (sclDriveLow || sampleStrobe || changeStrobe) bad++;
    end
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (sclDriveLow || sampleStrobe || changeStrobe) bad++;
    end
    check("R1 outputs quiet in reset and while disabled", bad, 0);
  endtask

  task automatic testBasic();    runPeriod("basic", 5, 4, 1, 5, 4, 1); endtask
  task automatic testPrescale(); runPeriod("R5 prescale", 5, 4, 3, 5, 4, 3); endtask
  task automatic testZero();     runPeriod("R4 R5 zero", 0, 0, 0, 1, 1, 1); endtask
  task automatic testExt();      runPeriod("R3 ext", 9'h1FF, 9'h100, 1, 511, 256, 1); endtask

  task automatic testStretch();
    int bad = 0;
    configure(4, 5, 1);
    enable = 1'b1;
    do @(negedge clk); while (!sclDriveLow);
    stretch = 1'b1;
    do @(negedge clk); while (sclDriveLow);
    for (int i = 0; i <= 10; i++) begin
      if (sampleStrobe || sclDriveLow) bad++;
      if (i < 10) @(negedge clk);
    end
    check("R7 no high phase while stretched", bad, 0);
    stretch = 1'b0;
    relLen = 0;
    while (!sampleStrobe) begin @(negedge clk); relLen++; end
    check("R6 sample 3 clocks after line high", relLen, 3);
    highLen = 0;
    while (!sclDriveLow) begin highLen++; @(negedge clk); end
    check("R8 high length after stretch", highLen, 5);
  endtask

  task automatic testDisable();
    int bad = 0;
    configure(6, 6, 1);
    enable = 1'b1;
    do @(negedge clk); while (!sclDriveLow);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclDriveLow || sampleStrobe || changeStrobe) bad++;
    end
    check("R10 quiet after disable", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R10 drive on re-enable", sclDriveLow, 1);
    lowLen = 0; midIdx = -1;
    while (sclDriveLow) begin
      if (changeStrobe && midIdx < 0) midIdx = lowLen;
      lowLen++;
      @(negedge clk);
    end
    check("R10 fresh low length", lowLen, 6);
    check("R10 R9 fresh change index", midIdx, 3);
  endtask

  initial begin
    testReset();
    testBasic();
    testPrescale();
    testZero();
    testExt();
    testStretch();
    testDisable();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule